// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Pair

This block does 32-bit integer multiply and divide for a processor core. Each operation runs over several cycles. The block owns a pair of result registers, called HI and LO. One command port carries a valid strobe and a 6-bit function code. A multiply places the 64-bit product across the pair. A divide places the quotient in LO and the remainder in HI. Four accessor commands read and write HI and LO one at a time.

An arithmetic command takes one setup cycle and then 32 iteration cycles. Multiply adds shifted copies of the multiplicand. Divide uses restoring shift-and-subtract. Signed commands first work on the operand magnitudes and then fix the signs of the results. While an operation runs, `busy` is high and most commands are dropped. The one exception is the first read of HI or LO. That read is held and answered as soon as the result is written.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, HI and LO are zero, `busy` is low, `rd_valid` is low and `rd_data` is zero.
- R2: Function codes are 0x10 read HI, 0x11 write HI, 0x12 read LO, 0x13 write LO, 0x18 signed multiply, 0x19 unsigned multiply, 0x1A signed divide and 0x1B unsigned divide. Any other code changes nothing.
- R3: A multiply writes bits 63..32 of the product to HI and bits 31..0 to LO. The operands are two's complement for 0x18 and unsigned for 0x19.
- R4: A divide writes the quotient to LO and the remainder to HI. For 0x1A the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. A most-negative dividend divided by -1 gives LO = 0x80000000 and HI = 0.
- R5: `busy` rises on the edge that accepts a multiply or divide and stays high for exactly 33 cycles. HI and LO take the result on the edge where `busy` falls, unless a held read is pending (see R9).
- R6: When idle, a read command gives `rd_valid` high for the cycle after its accepting edge, with the register value in `rd_data`. `rd_data` keeps its last value at all other times.
- R7: When idle, a write command loads `op_a` into HI or LO on its accepting edge.
- R8: While `busy` is high, write, multiply, divide and unknown commands have no effect on HI, LO or the timing of the running operation.
- R9: The first read command that arrives while an operation runs is held. It is answered with the new result one cycle after the result edge, and `busy` stays high until that answer. Further reads made while the held read waits are dropped.
- R10: Divide by zero takes the normal 33 cycles and raises no error. The unsigned form gives LO = 0xFFFFFFFF and HI = dividend. The signed form applies R4 to a magnitude quotient of all ones, so a negative dividend gives LO = 1 and HI = dividend.
- R11: `rd_valid` goes high only in answer to a read command, whether taken at once or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_func | input | 6 | Function code (R2) |
| op_a | input | 32 | First operand; data for writes; multiplicand or dividend |
| op_b | input | 32 | Second operand; multiplier or divisor |
| busy | output | 1 | Operation running or held read pending |
| rd_valid | output | 1 | Read answer strobe |
| rd_data | output | 32 | Read answer data |

## Verification
Faults in the sign fix or in an iteration step show up only when HI or LO is read. The bench therefore reads both registers after every operation and compares them with a reference computed from whole-number arithmetic. A wrong step count or a sequencer that gets stuck makes `busy` differ from the model within one cycle of the expected fall. A bad pending-read flag shows up in the cycle after the result edge, as a missing, extra or stale `rd_valid`. Commands are also sent at random times during busy windows, so a dropped command that leaks into HI or LO shows up on the next read.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [5:0] FN_RD_HI = 6'h10;
  localparam logic [5:0] FN_WR_HI = 6'h11;
  localparam logic [5:0] FN_RD_LO = 6'h12;
  localparam logic [5:0] FN_WR_LO = 6'h13;
  localparam logic [5:0] FN_MUL_S = 6'h18;
  localparam logic [5:0] FN_MUL_U = 6'h19;
  localparam logic [5:0] FN_DIV_S = 6'h1A;
  localparam logic [5:0] FN_DIV_U = 6'h1B;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic setup_fire,
  output logic step_fire,
  output logic last_fire,
  output logic active
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

  seq_state_t state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) state_q <= SEQ_SETUP;
        SEQ_SETUP: begin
          state_q <= SEQ_RUN;
          cnt_q   <= '0;
        end
        SEQ_RUN: begin
          if (cnt_q == LAST_IDX) state_q <= SEQ_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    setup_fire = (state_q == SEQ_SETUP);
    step_fire  = (state_q == SEQ_RUN);
    last_fire  = (state_q == SEQ_RUN) && (cnt_q == LAST_IDX);
    active     = (state_q != SEQ_IDLE);
  end

  AST_SETUP_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    setup_fire |=> (step_fire && cnt_q == '0)); // R5
  AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> !active); // R5
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> setup_fire); // R5
endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_mag,
  input  logic [W-1:0]   b_mag,
  output logic [2*W-1:0] prod_next
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod_q;
  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;

  // One shift-add iteration: add the multiplicand when the low multiplier bit is set.
  function automatic logic [PW-1:0] add_partial(input logic [PW-1:0] acc,
                                                input logic [PW-1:0] cand,
                                                input logic          bit_set);
    return bit_set ? (acc + cand) : acc;
  endfunction

  assign prod_next = add_partial(prod_q, mcand_q, mplier_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q   <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load) begin
      prod_q   <= '0;
      mcand_q  <= {{W{1'b0}}, a_mag};
      mplier_q <= b_mag;
    end else if (step) begin
      prod_q   <= prod_next;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  AST_MUL_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (a_mag == '0 || b_mag == '0)) |=> (prod_q == '0)); // R3
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_next,
  output logic [W-1:0] rem_next
);
  logic [W-1:0] rem_q;
  logic [W-1:0] dvd_q;
  logic [W-1:0] dvs_q;

  logic [W:0] shifted;
  logic [W:0] trial;
  logic       fits;

  // Restoring step: bring in the next dividend bit, then try to subtract the divisor.
  function automatic logic [W:0] try_sub(input logic [W:0] part,
                                         input logic [W-1:0] divisor);
    return part - {1'b0, divisor};
  endfunction

  always_comb begin
    shifted  = {rem_q, dvd_q[W-1]};
    trial    = try_sub(shifted, dvs_q);
    fits     = ~trial[W];
    rem_next = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_next = {dvd_q[W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      dvd_q <= dvd_mag;
      dvs_q <= dvs_mag;
    end else if (step) begin
      rem_q <= rem_next;
      dvd_q <= quo_next;
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dvs_q != '0) |=> (rem_q < dvs_q)); // R4
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [5:0]   cmd_func,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int PW = 2 * W;

  logic [W-1:0] hi_q, lo_q;
  logic [W-1:0] a_q, b_q;
  logic         is_div_q, is_signed_q;
  logic         pend_q, pend_hi_q;

  logic is_rd, is_arith, accept, start;
  logic setup_fire, step_fire, last_fire, active;
  logic neg_a, neg_b;
  logic [W-1:0]  a_mag, b_mag;
  logic [PW-1:0] prod_raw, prod_fix;
  logic [W-1:0]  quo_raw, rem_raw, quo_fix, rem_fix;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [W-1:0] apply_sign_w(input logic [W-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [PW-1:0] apply_sign_p(input logic [PW-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  // Command decode
  always_comb begin
    is_rd    = (cmd_func == FN_RD_HI) || (cmd_func == FN_RD_LO);
    is_arith = (cmd_func == FN_MUL_S) || (cmd_func == FN_MUL_U) ||
               (cmd_func == FN_DIV_S) || (cmd_func == FN_DIV_U);
    busy     = active | pend_q;
    accept   = cmd_valid & ~busy;
    start    = accept & is_arith;
  end

  // Operand capture on acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q         <= '0;
      b_q         <= '0;
      is_div_q    <= 1'b0;
      is_signed_q <= 1'b0;
    end else if (start) begin
      a_q         <= op_a;
      b_q         <= op_b;
      is_div_q    <= cmd_func[1];
      is_signed_q <= ~cmd_func[0];
    end
  end

  always_comb begin
    neg_a = is_signed_q & a_q[W-1];
    neg_b = is_signed_q & b_q[W-1];
    a_mag = magnitude(a_q, neg_a);
    b_mag = magnitude(b_q, neg_b);
  end

  mdu_seq #(.STEPS(W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .setup_fire (setup_fire),
    .step_fire  (step_fire),
    .last_fire  (last_fire),
    .active     (active)
  );

  mdu_mul_core #(.W(W)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (setup_fire & ~is_div_q),
    .step      (step_fire & ~is_div_q),
    .a_mag     (a_mag),
    .b_mag     (b_mag),
    .prod_next (prod_raw)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (setup_fire & is_div_q),
    .step     (step_fire & is_div_q),
    .dvd_mag  (a_mag),
    .dvs_mag  (b_mag),
    .quo_next (quo_raw),
    .rem_next (rem_raw)
  );

  // Sign fix-up of the final iteration's outputs
  always_comb begin
    prod_fix = apply_sign_p(prod_raw, neg_a ^ neg_b);
    quo_fix  = apply_sign_w(quo_raw, neg_a ^ neg_b);
    rem_fix  = apply_sign_w(rem_raw, neg_a);
  end

  // HI/LO pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last_fire) begin
      if (is_div_q) begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end else begin
        hi_q <= prod_fix[PW-1:W];
        lo_q <= prod_fix[W-1:0];
      end
    end else if (accept && cmd_func == FN_WR_HI) begin
      hi_q <= op_a;
    end else if (accept && cmd_func == FN_WR_LO) begin
      lo_q <= op_a;
    end
  end

  // Read port and held read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      pend_q    <= 1'b0;
      pend_hi_q <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (accept && is_rd) begin
        rd_valid <= 1'b1;
        rd_data  <= (cmd_func == FN_RD_HI) ? hi_q : lo_q;
      end else if (pend_q && !active) begin
        rd_valid <= 1'b1;
        rd_data  <= pend_hi_q ? hi_q : lo_q;
        pend_q   <= 1'b0;
      end
      if (cmd_valid && is_rd && active && !pend_q) begin
        pend_q    <= 1'b1;
        pend_hi_q <= (cmd_func == FN_RD_HI);
      end
    end
  end

  AST_HILO_HELD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_fire) |=> ($stable(hi_q) && $stable(lo_q))); // R8
  AST_HELD_READ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !active) |=> (rd_valid && !pend_q)); // R9
  AST_RESULT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (busy == pend_q)); // R5
  AST_RDV_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> ($past(cmd_valid && is_rd) || $past(pend_q))); // R11
endmodule

// File: tb/mdu_hilo_test.sv
module mdu_hilo_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [5:0]  cmd_func;
  logic [31:0] op_a, op_b;
  logic        busy, rd_valid;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mdu_hilo uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .op_a(op_a), .op_b(op_b), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Reference model state
  logic [31:0] m_hi, m_lo, m_rdd;
  logic [63:0] m_res;
  int          m_left;
  bit          m_pend, m_pend_hi, m_rdv;

  function automatic logic [63:0] expect_result(input logic [5:0] f,
                                                input logic [31:0] a,
                                                input logic [31:0] b);
    longint sa, sb, sq, sr;
    logic [63:0] u;
    logic [31:0] q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      6'h18: begin sq = sa * sb; return sq; end
      6'h19: begin u = {32'd0, a} * {32'd0, b}; return u; end
      6'h1A: begin
        if (b == 0) begin
          r = a;
          q = a[31] ? 32'd1 : 32'hFFFF_FFFF; // R10
        end else begin
          sq = sa / sb; sr = sa % sb;
          q = sq[31:0]; r = sr[31:0];
        end
        return {r, q};
      end
      default: begin
        if (b == 0) begin r = a; q = 32'hFFFF_FFFF; end // R10
        else begin q = a / b; r = a % b; end
        return {r, q};
      end
    endcase
  endfunction

  always @(posedge clk) begin
    bit was_busy, was_run, was_pend;
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_rdd = 0; m_rdv = 0;
      m_left = 0; m_pend = 0; m_pend_hi = 0; m_res = 0;
    end else begin
      was_run  = (m_left > 0);
      was_pend = m_pend;
      was_busy = was_run || was_pend;
      m_rdv = 0;
      if (was_run) begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_hi = m_res[63:32]; m_lo = m_res[31:0]; end
      end else if (was_pend) begin
        m_rdv = 1; m_rdd = m_pend_hi ? m_hi : m_lo; m_pend = 0;
      end
      if (cmd_valid) begin
        if (!was_busy) begin
          case (cmd_func)
            6'h10: begin m_rdv = 1; m_rdd = m_hi; end
            6'h12: begin m_rdv = 1; m_rdd = m_lo; end
            6'h11: m_hi = op_a;
            6'h13: m_lo = op_a;
            6'h18, 6'h19, 6'h1A, 6'h1B: begin
              m_res = expect_result(cmd_func, op_a, op_b);
              m_left = 33;
            end
            default: ;
          endcase
        end else if (was_run && !was_pend &&
                     (cmd_func == 6'h10 || cmd_func == 6'h12)) begin
          m_pend = 1; m_pend_hi = (cmd_func == 6'h10);
        end
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on && rst_n && !finished) begin
      check("R5", "busy", {31'd0, busy}, {31'd0, (m_left > 0) || m_pend});
      check(cur_req, "rd_valid", {31'd0, rd_valid}, {31'd0, m_rdv});
      check(cur_req, "rd_data", rd_data, m_rdd);
    end
  end

  task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; op_a = a; op_b = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_func = 6'h00; op_a = 32'h0; op_b = 32'h0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic op_and_read(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    issue(f, a, b);
    gap(34);
    issue(6'h10, 0, 0);
    issue(6'h12, 0, 0);
    gap(1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_func = 6'h00; op_a = 0; op_b = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "busy", {31'd0, busy}, 32'd0);
    check("R1", "rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1", "rd_data", rd_data, 32'd0);
    rst_n = 1'b1;
    cmp_on = 1;
    cur_req = "R1"; issue(6'h10, 0, 0); issue(6'h12, 0, 0); gap(1);

    cur_req = "R7"; // writes then reads (R6)
    issue(6'h11, 32'hDEAD_BEEF, 0);
    issue(6'h13, 32'h1234_5678, 0);
    cur_req = "R6";
    issue(6'h10, 0, 0); issue(6'h12, 0, 0); gap(3);

    cur_req = "R2"; // unknown codes change nothing
    issue(6'h1F, 32'h1111_1111, 32'h2); issue(6'h00, 32'h2222_2222, 0);
    issue(6'h14, 32'h3333_3333, 0);
    issue(6'h10, 0, 0); issue(6'h12, 0, 0); gap(2);

    cur_req = "R3";
    op_and_read(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    op_and_read(6'h18, 32'hFFFF_FFFD, 32'd7);
    op_and_read(6'h18, 32'h8000_0000, 32'h8000_0000);
    op_and_read(6'h18, 32'd12345, 32'd6789);
    op_and_read(6'h19, 32'h8000_0001, 32'd3);

    cur_req = "R4";
    op_and_read(6'h1A, 32'hFFFF_FFF9, 32'd2);
    op_and_read(6'h1A, 32'd7, 32'hFFFF_FFFE);
    op_and_read(6'h1B, 32'd100, 32'd7);
    op_and_read(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF);
    op_and_read(6'h1B, 32'hFFFF_FFFF, 32'h8000_0000);

    cur_req = "R10";
    op_and_read(6'h1B, 32'd5, 32'd0);
    op_and_read(6'h1A, 32'hFFFF_FFFB, 32'd0);
    op_and_read(6'h1A, 32'd9, 32'd0);

    cur_req = "R8"; // writes and new ops while busy are dropped
    issue(6'h19, 32'd3, 32'd5);
    issue(6'h11, 32'hAAAA_AAAA, 0);
    issue(6'h13, 32'hBBBB_BBBB, 0);
    issue(6'h1B, 32'd50, 32'd5);
    gap(30);
    issue(6'h10, 0, 0); issue(6'h12, 0, 0); gap(3);

    cur_req = "R9"; // held read, extra read dropped
    issue(6'h18, 32'hFFFF_FFFF, 32'd2);
    issue(6'h12, 0, 0);
    issue(6'h10, 0, 0);
    gap(36);
    issue(6'h1B, 32'd77, 32'd10);
    gap(31);
    issue(6'h10, 0, 0); // arrives on the result edge
    gap(4);
    issue(6'h11, 32'h5, 0); // R11: writes give no rd_valid
    gap(2);

    cur_req = "R8";
    for (int i = 0; i < 60; i++) begin
      logic [5:0] f;
      logic [31:0] b;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: f = 6'h10; 1: f = 6'h11; 2: f = 6'h12; 3: f = 6'h13;
        4: f = 6'h18; 5: f = 6'h19; 6: f = 6'h1A; 7: f = 6'h1B;
        8: f = 6'h15; default: f = 6'h1A;
      endcase
      b = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
      issue(f, $urandom, b);
      gap($urandom_range(0, 40));
    end
    gap(40);
    issue(6'h10, 0, 0); issue(6'h12, 0, 0); gap(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog %s: actual=hung expected=done", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule